// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

The block merges four rectangular layers into one RGB raster, one pixel per cycle. Each layer presents an ARGB8888 pixel for the current raster coordinate, plus a window (origin and size), an enable, a pipe select, a 2-bit priority and an 8-bit global alpha with its own enable. A display width and height bound the raster. Coordinates outside that area produce no output pixel.

Composition has two steps. Inside each of the two pipes, the enabled covering layer with the highest priority wins the pixel, and the other layers in that pipe are hidden entirely. The two pipe winners are then alpha-blended: pipe 0 over a background color register, and pipe 1 over that result. A per-block erratum mode copies a known hardware defect. A pipe-0 winner at priority 0 that carries any transparency is dropped, so the background shows through.

Top module: `dual_pipe_compositor`

## Requirements
- R1: While rst_ni is low and after its release, pix_valid_o is 0 and the background register is 0x000000 (black).
- R2: A coordinate presented with pix_valid_i in cycle N gives pix_valid_o and pix_rgb_o after exactly two rising edges. Output valid is 0 in cycles with no matching input.
- R3: A coordinate with pix_x_i >= disp_w_i or pix_y_i >= disp_h_i produces pix_valid_o = 0.
- R4: Layer i covers (x, y) only when its enable bit lay_en_i[i] is 1, lay_x <= x < lay_x + lay_w and lay_y <= y < lay_y + lay_h. A zero size covers nothing.
- R5: Within one pipe (lay_pipe_i[i] = 0 selects pipe 0, 1 selects pipe 1), the covering layer with the largest priority lay_prio_i[2i+1:2i] supplies the pipe pixel. On equal priority, the lower layer index wins.
- R6: The output is c0 = mix(a0, p0, bg) and then out = mix(a1, p1, c0) per channel, where mix(a, t, b) = (a*t + (255-a)*b + 127) / 255 (floor). Layers that lose inside a pipe do not contribute, whatever the winner's alpha.
- R7: Pixel alpha is ARGB bits [31:24], with color R [23:16], G [15:8], B [7:0]. When lay_galpha_en_i[i] is 1, the effective alpha is (a*g + 127) / 255 with g = lay_galpha_i[8i+7:8i]. Otherwise it is a.
- R8: A pipe with no covering layer contributes alpha 0. With no layer covering, the output equals the background color.
- R9: bg_we_i high at a rising edge loads bg_color_i into the background register. Pixels composed afterwards use the new color.
- R10: With erratum_en_i = 1, a pipe-0 winner whose priority is 0 and whose effective alpha is below 255 contributes alpha 0. With erratum_en_i = 0, the same pixel is blended normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_w_i | input | CW | Display width in pixels |
| disp_h_i | input | CW | Display height in lines |
| bg_we_i | input | 1 | Background color load strobe |
| bg_color_i | input | 24 | Background RGB to load |
| erratum_en_i | input | 1 | Enables the lowest-layer alpha defect mode |
| lay_en_i | input | NL | Per-layer enable |
| lay_pipe_i | input | NL | Per-layer pipe select |
| lay_prio_i | input | 2*NL | Per-layer 2-bit priority |
| lay_x_i | input | CW*NL | Per-layer window origin x |
| lay_y_i | input | CW*NL | Per-layer window origin y |
| lay_w_i | input | CW*NL | Per-layer window width |
| lay_h_i | input | CW*NL | Per-layer window height |
| lay_galpha_i | input | 8*NL | Per-layer global alpha |
| lay_galpha_en_i | input | NL | Per-layer global alpha enable |
| lay_argb_i | input | 32*NL | Per-layer ARGB8888 pixel for the current coordinate |
| pix_valid_i | input | 1 | Coordinate valid |
| pix_x_i | input | CW | Raster x |
| pix_y_i | input | CW | Raster y |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 24 | Composited RGB pixel |

## Verification
A vector table sweeps layer set-ups that each isolate one decision. A single opaque layer shows pass-through. Two same-pipe layers, with distinct and then equal priorities, separate the priority order from the index tie-break. A transparent winner stacked on an opaque loser shows that hiding happens inside a pipe. Cross-pipe pairs show that blending happens only between pipes. Global alpha on and off shows the alpha scaling, and the erratum on and off gives the same pixel two different results. Directed cases pin the window edges at origin+size-1 versus origin+size, the display-size edge, the two-edge latency, the background load and a hand-computed 50% blend.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef struct packed {
    logic [7:0]  alpha;
    logic [23:0] rgb;
  } pipe_px_t;

  // (a*t + (255-a)*b + 127) / 255
  function automatic logic [7:0] mix8(input logic [7:0] a, input logic [7:0] t,
                                      input logic [7:0] b);
    logic [16:0] s;
    s = 17'(a) * 17'(t) + 17'(8'd255 - a) * 17'(b) + 17'd127;
    return 8'(s / 17'd255);
  endfunction

  function automatic logic [23:0] mix24(input logic [7:0] a, input logic [23:0] t,
                                        input logic [23:0] b);
    return {mix8(a, t[23:16], b[23:16]), mix8(a, t[15:8], b[15:8]), mix8(a, t[7:0], b[7:0])};
  endfunction
endpackage

// File: rtl/dpc_layer_hit.sv
module dpc_layer_hit #(
  parameter int CW = 12
) (
  input  logic          en_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic [CW-1:0] w_i,
  input  logic [CW-1:0] h_i,
  input  logic [CW-1:0] px_i,
  input  logic [CW-1:0] py_i,
  input  logic [31:0]   argb_i,
  input  logic [7:0]    galpha_i,
  input  logic          galpha_en_i,
  output logic          hit_o,
  output logic [7:0]    alpha_o,
  output logic [23:0]   rgb_o
);
  logic [CW:0] x_end, y_end;
  logic        in_x, in_y;

  assign x_end = {1'b0, x_i} + {1'b0, w_i};
  assign y_end = {1'b0, y_i} + {1'b0, h_i};
  assign in_x  = (px_i >= x_i) && ({1'b0, px_i} < x_end);
  assign in_y  = (py_i >= y_i) && ({1'b0, py_i} < y_end);
  assign hit_o = en_i && in_x && in_y;
  assign rgb_o = argb_i[23:0];

  // galpha scaling equals mix against zero
  assign alpha_o = galpha_en_i ? dpc_pkg::mix8(argb_i[31:24], galpha_i, 8'd0) : argb_i[31:24];
endmodule

// File: rtl/dpc_pipe_select.sv
module dpc_pipe_select #(
  parameter int NL      = 4,
  parameter int PW      = 2,
  parameter bit PIPE_ID = 1'b0
) (
  input  logic              erratum_i,
  input  logic [NL-1:0]     hit_i,
  input  logic [NL-1:0]     pipe_i,
  input  logic [PW-1:0]     prio_i  [NL],
  input  logic [7:0]        alpha_i [NL],
  input  logic [23:0]       rgb_i   [NL],
  output dpc_pkg::pipe_px_t px_o
);
  logic          found;
  logic [PW-1:0] best_prio;
  logic [7:0]    best_a;
  logic [23:0]   best_rgb;
  logic          drop;

  always_comb begin
    found     = 1'b0;
    best_prio = '0;
    best_a    = '0;
    best_rgb  = '0;
    for (int i = 0; i < NL; i++) begin
      if (hit_i[i] && (pipe_i[i] == PIPE_ID) && (!found || prio_i[i] > best_prio)) begin
        found     = 1'b1;
        best_prio = prio_i[i];
        best_a    = alpha_i[i];
        best_rgb  = rgb_i[i];
      end
    end
  end

  generate
    if (PIPE_ID == 1'b0) begin : g_errata
      assign drop = erratum_i && (best_prio == '0) && (best_a != 8'hFF);
    end else begin : g_plain
      assign drop = 1'b0;
    end
  endgenerate

  assign px_o.alpha = (found && !drop) ? best_a : 8'd0;
  assign px_o.rgb   = best_rgb;
endmodule

// File: rtl/dpc_blend.sv
module dpc_blend (
  input  dpc_pkg::pipe_px_t p0_i,
  input  dpc_pkg::pipe_px_t p1_i,
  input  logic [23:0]       bg_i,
  output logic [23:0]       rgb_o
);
  logic [23:0] lower;
  assign lower = dpc_pkg::mix24(p0_i.alpha, p0_i.rgb, bg_i);
  assign rgb_o = dpc_pkg::mix24(p1_i.alpha, p1_i.rgb, lower);
endmodule

// File: rtl/dual_pipe_compositor.sv
module dual_pipe_compositor #(
  parameter int CW = 12,
  parameter int NL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    disp_w_i,
  input  logic [CW-1:0]    disp_h_i,
  input  logic             bg_we_i,
  input  logic [23:0]      bg_color_i,
  input  logic             erratum_en_i,
  input  logic [NL-1:0]    lay_en_i,
  input  logic [NL-1:0]    lay_pipe_i,
  input  logic [2*NL-1:0]  lay_prio_i,
  input  logic [CW*NL-1:0] lay_x_i,
  input  logic [CW*NL-1:0] lay_y_i,
  input  logic [CW*NL-1:0] lay_w_i,
  input  logic [CW*NL-1:0] lay_h_i,
  input  logic [8*NL-1:0]  lay_galpha_i,
  input  logic [NL-1:0]    lay_galpha_en_i,
  input  logic [32*NL-1:0] lay_argb_i,
  input  logic             pix_valid_i,
  input  logic [CW-1:0]    pix_x_i,
  input  logic [CW-1:0]    pix_y_i,
  output logic             pix_valid_o,
  output logic [23:0]      pix_rgb_o
);
  import dpc_pkg::*;
  localparam int PW = 2;

  logic [23:0]   bg_q;
  logic [NL-1:0] hit;
  logic [7:0]    alpha [NL];
  logic [23:0]   rgb   [NL];
  logic [PW-1:0] prio  [NL];
  pipe_px_t      pipe_px [2];
  pipe_px_t      p0_q, p1_q;
  logic          v1_q;
  logic [23:0]   blend_rgb;
  logic          in_disp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bg_q <= '0;
    else if (bg_we_i) bg_q <= bg_color_i;
  end

  generate
    for (genvar i = 0; i < NL; i++) begin : g_layer
      assign prio[i] = lay_prio_i[PW*i +: PW];
      dpc_layer_hit #(.CW(CW)) u_hit (
        .en_i       (lay_en_i[i]),
        .x_i        (lay_x_i[CW*i +: CW]),
        .y_i        (lay_y_i[CW*i +: CW]),
        .w_i        (lay_w_i[CW*i +: CW]),
        .h_i        (lay_h_i[CW*i +: CW]),
        .px_i       (pix_x_i),
        .py_i       (pix_y_i),
        .argb_i     (lay_argb_i[32*i +: 32]),
        .galpha_i   (lay_galpha_i[8*i +: 8]),
        .galpha_en_i(lay_galpha_en_i[i]),
        .hit_o      (hit[i]),
        .alpha_o    (alpha[i]),
        .rgb_o      (rgb[i])
      );
    end
    for (genvar p = 0; p < 2; p++) begin : g_pipe
      dpc_pipe_select #(.NL(NL), .PW(PW), .PIPE_ID(p[0])) u_sel (
        .erratum_i(erratum_en_i),
        .hit_i    (hit),
        .pipe_i   (lay_pipe_i),
        .prio_i   (prio),
        .alpha_i  (alpha),
        .rgb_i    (rgb),
        .px_o     (pipe_px[p])
      );
    end
  endgenerate

  assign in_disp = (pix_x_i < disp_w_i) && (pix_y_i < disp_h_i);

  // stage 1: per-pipe winners
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      p0_q <= '0;
      p1_q <= '0;
    end else begin
      v1_q <= pix_valid_i && in_disp;
      p0_q <= pipe_px[0];
      p1_q <= pipe_px[1];
    end
  end

  dpc_blend u_blend (
    .p0_i (p0_q),
    .p1_i (p1_q),
    .bg_i (bg_q),
    .rgb_o(blend_rgb)
  );

  // stage 2: blended output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_rgb_o   <= '0;
    end else begin
      pix_valid_o <= v1_q;
      pix_rgb_o   <= blend_rgb;
    end
  end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int CW = 12,
  parameter int NL = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] disp_w_i,
  input logic [CW-1:0] disp_h_i,
  input logic [NL-1:0] lay_en_i,
  input logic          pix_valid_i,
  input logic [CW-1:0] pix_x_i,
  input logic [CW-1:0] pix_y_i,
  input logic          pix_valid_o,
  input logic [23:0]   pix_rgb_o,
  input logic [23:0]   bg_q
);
  logic [1:0] age_q;
  logic       in_disp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign in_disp = (pix_x_i < disp_w_i) && (pix_y_i < disp_h_i);

  p_reset_quiet_r1: assert property (@(posedge clk_i) !rst_ni |-> !pix_valid_o);

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (pix_valid_o == $past(pix_valid_i && in_disp, 2)));

  p_out_of_disp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd2) && $past(pix_valid_i && !in_disp, 2)) |-> !pix_valid_o);

  p_empty_shows_bg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd2) && pix_valid_o && ($past(lay_en_i, 2) == '0)) |-> (pix_rgb_o == $past(bg_q)));
endmodule

bind dual_pipe_compositor dpc_checker #(.CW(CW), .NL(NL)) u_dpc_checker (.*);

// File: tb/tb_dual_pipe_compositor.sv
module tb_dual_pipe_compositor;
  localparam int CW = 12;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [CW-1:0]    disp_w, disp_h;
  logic             bg_we;
  logic [23:0]      bg_color;
  logic             erratum_en;
  logic [NL-1:0]    lay_en, lay_pipe, lay_gen;
  logic [2*NL-1:0]  lay_prio;
  logic [CW*NL-1:0] lay_x, lay_y, lay_w, lay_h;
  logic [8*NL-1:0]  lay_ga;
  logic [32*NL-1:0] lay_argb;
  logic             pv_i;
  logic [CW-1:0]    px, py;
  logic             pv_o;
  logic [23:0]      rgb_o;

  dual_pipe_compositor #(.CW(CW), .NL(NL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .disp_w_i(disp_w), .disp_h_i(disp_h),
    .bg_we_i(bg_we), .bg_color_i(bg_color), .erratum_en_i(erratum_en),
    .lay_en_i(lay_en), .lay_pipe_i(lay_pipe), .lay_prio_i(lay_prio),
    .lay_x_i(lay_x), .lay_y_i(lay_y), .lay_w_i(lay_w), .lay_h_i(lay_h),
    .lay_galpha_i(lay_ga), .lay_galpha_en_i(lay_gen), .lay_argb_i(lay_argb),
    .pix_valid_i(pv_i), .pix_x_i(px), .pix_y_i(py),
    .pix_valid_o(pv_o), .pix_rgb_o(rgb_o)
  );

  int checks = 0;
  int errors = 0;
  logic [23:0] bg_model = 24'h000000;

  // fixed windows: L0 (0,0,100,100) L1 (50,50,100,100) L2 (20,20,40,40) L3 (200,200,10,10)
  localparam logic [CW*NL-1:0] WX = {12'd200, 12'd20, 12'd50, 12'd0};
  localparam logic [CW*NL-1:0] WY = {12'd200, 12'd20, 12'd50, 12'd0};
  localparam logic [CW*NL-1:0] WW = {12'd10, 12'd40, 12'd100, 12'd100};
  localparam logic [CW*NL-1:0] WH = {12'd10, 12'd40, 12'd100, 12'd100};

  typedef struct packed {
    logic [3:0]   en;
    logic [3:0]   pipe;
    logic [7:0]   prio;
    logic [3:0]   gen;
    logic [31:0]  ga;
    logic [127:0] argb;
    logic [11:0]  x;
    logic [11:0]  y;
    logic         erra;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    // R4 single opaque layer inside window
    '{4'b0001, 4'b0000, 8'h00, 4'h0, 32'h0, {96'h0, 32'hFF112233}, 12'd10, 12'd10, 1'b0},
    // R4 enabled layer, coordinate outside window
    '{4'b0001, 4'b0000, 8'h00, 4'h0, 32'h0, {96'h0, 32'hFF112233}, 12'd150, 12'd10, 1'b0},
    // R5 higher priority wins in pipe 0
    '{4'b0011, 4'b0000, 8'h04, 4'h0, 32'h0, {64'h0, 32'hFF00FF00, 32'hFFFF0000}, 12'd60, 12'd60, 1'b0},
    // R5 equal priority, lower index wins
    '{4'b0011, 4'b0000, 8'h0A, 4'h0, 32'h0, {64'h0, 32'hFF00FF00, 32'hFFFF0000}, 12'd60, 12'd60, 1'b0},
    // R6 pipe 1 half-transparent over pipe 0
    '{4'b0011, 4'b0010, 8'h00, 4'h0, 32'h0, {64'h0, 32'h800000FF, 32'hFFFF0000}, 12'd60, 12'd60, 1'b0},
    // R6 transparent winner hides opaque loser in same pipe
    '{4'b0101, 4'b0000, 8'h30, 4'h0, 32'h0, {32'h0, 32'h40FFFFFF, 32'h0, 32'hFF123456}, 12'd30, 12'd30, 1'b0},
    // R7 global alpha scales pixel alpha
    '{4'b0001, 4'b0001, 8'h00, 4'h1, 32'h00000080, {96'h0, 32'hFF00FF00}, 12'd10, 12'd10, 1'b0},
    // R10 erratum drops translucent pipe-0 priority-0 winner
    '{4'b0001, 4'b0000, 8'h00, 4'h0, 32'h0, {96'h0, 32'h80FF0000}, 12'd10, 12'd10, 1'b1},
    // R10 erratum off blends the same pixel
    '{4'b0001, 4'b0000, 8'h00, 4'h0, 32'h0, {96'h0, 32'h80FF0000}, 12'd10, 12'd10, 1'b0},
    // R8 pipe 1 only, pipe 0 empty
    '{4'b1000, 4'b1000, 8'h40, 4'h0, 32'h0, {32'h80ABCDEF, 96'h0}, 12'd205, 12'd205, 1'b0}
  };

  function automatic logic [7:0] m8(input int a, input int t, input int b);
    return 8'((a * t + (255 - a) * b + 127) / 255);
  endfunction

  function automatic logic [23:0] m24(input int a, input logic [23:0] t, input logic [23:0] b);
    return {m8(a, t[23:16], b[23:16]), m8(a, t[15:8], b[15:8]), m8(a, t[7:0], b[7:0])};
  endfunction

  function automatic logic [23:0] model(input vec_t v, input logic [23:0] bg);
    int          wa[2];
    logic [23:0] wc[2];
    int          wp[2];
    logic [23:0] c0;
    for (int p = 0; p < 2; p++) begin
      wa[p] = 0; wc[p] = 0; wp[p] = -1;
    end
    for (int i = 0; i < NL; i++) begin
      int lx = int'(WX[12*i +: 12]);
      int ly = int'(WY[12*i +: 12]);
      int pp = int'(v.pipe[i]);
      int pr = int'(v.prio[2*i +: 2]);
      int a  = int'(v.argb[32*i+24 +: 8]);
      if (v.gen[i]) a = (a * int'(v.ga[8*i +: 8]) + 127) / 255;
      if (v.en[i] && int'(v.x) >= lx && int'(v.x) < lx + int'(WW[12*i +: 12]) &&
          int'(v.y) >= ly && int'(v.y) < ly + int'(WH[12*i +: 12]) && pr > wp[pp]) begin
        wp[pp] = pr; wa[pp] = a; wc[pp] = v.argb[32*i +: 24];
      end
    end
    if (v.erra && wp[0] == 0 && wa[0] != 255) wa[0] = 0;
    c0 = m24(wa[0], wc[0], bg);
    return m24(wa[1], wc[1], c0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    lay_en = v.en; lay_pipe = v.pipe; lay_prio = v.prio; lay_gen = v.gen;
    lay_ga = v.ga; lay_argb = v.argb; erratum_en = v.erra;
  endtask

  // drive at negedge; result readable two rising edges later
  task automatic shoot(input logic [11:0] x, input logic [11:0] y, output logic v1, output logic v2,
                       output logic [23:0] c);
    @(negedge clk);
    px = x; py = y; pv_i = 1'b1;
    @(negedge clk);
    pv_i = 1'b0;
    v1 = pv_o;
    @(negedge clk);
    v2 = pv_o; c = rgb_o;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic v1, v2;
    logic [23:0] c;
    vec_t d;
    disp_w = 12'd640; disp_h = 12'd480;
    bg_we = 1'b0; bg_color = '0; erratum_en = 1'b0;
    lay_en = '0; lay_pipe = '0; lay_prio = '0; lay_gen = '0; lay_ga = '0; lay_argb = '0;
    lay_x = WX; lay_y = WY; lay_w = WW; lay_h = WH;
    pv_i = 1'b0; px = '0; py = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", 32'(pv_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 32'(pv_o), 32'd0);
    shoot(12'd5, 12'd5, v1, v2, c);
    check("R1 black background", 32'(c), 32'h000000);
    check("R2 valid not after one edge", 32'(v1), 32'd0);
    check("R2 valid after two edges", 32'(v2), 32'd1);

    for (int k = 0; k < NV; k++) begin
      load(VEC[k]);
      shoot(VEC[k].x, VEC[k].y, v1, v2, c);
      check($sformatf("vector %0d valid R2", k), 32'(v2), 32'd1);
      check($sformatf("vector %0d rgb R4/R5/R6/R7/R8/R10", k), 32'(c), 32'(model(VEC[k], bg_model)));
    end

    // R6 hand value: 0x80 blue over opaque red -> 7F0080
    load(VEC[4]);
    shoot(12'd60, 12'd60, v1, v2, c);
    check("R6 hand blend", 32'(c), 32'h7F0080);

    // R7 hand value: alpha FF scaled by 0x80 -> 0x80, green over black
    load(VEC[6]);
    shoot(12'd10, 12'd10, v1, v2, c);
    check("R7 hand global alpha", 32'(c), 32'h008000);

    // R4 window edges for L0 (0..99)
    d = VEC[0];
    load(d);
    shoot(12'd99, 12'd99, v1, v2, c);
    check("R4 last covered pixel", 32'(c), 32'h112233);
    shoot(12'd100, 12'd99, v1, v2, c);
    check("R4 first uncovered x", 32'(c), 32'h000000);
    shoot(12'd99, 12'd100, v1, v2, c);
    check("R4 first uncovered y", 32'(c), 32'h000000);
    d.en = 4'b0000;
    load(d);
    shoot(12'd10, 12'd10, v1, v2, c);
    check("R4 disabled layer", 32'(c), 32'h000000);

    // R3 display bounds
    load(VEC[0]);
    shoot(12'd639, 12'd479, v1, v2, c);
    check("R3 last displayed pixel valid", 32'(v2), 32'd1);
    shoot(12'd640, 12'd10, v1, v2, c);
    check("R3 x beyond width", 32'(v2), 32'd0);
    shoot(12'd10, 12'd480, v1, v2, c);
    check("R3 y beyond height", 32'(v2), 32'd0);

    // R9 background load
    @(negedge clk);
    bg_color = 24'h204060; bg_we = 1'b1;
    @(negedge clk);
    bg_we = 1'b0; bg_color = 24'hFFFFFF;
    bg_model = 24'h204060;
    lay_en = '0;
    shoot(12'd10, 12'd10, v1, v2, c);
    check("R9 R8 new background shown", 32'(c), 32'h204060);
    load(VEC[7]);
    shoot(12'd10, 12'd10, v1, v2, c);
    check("R10 erratum shows new background", 32'(c), 32'h204060);
    load(VEC[8]);
    shoot(12'd10, 12'd10, v1, v2, c);
    check("R10 erratum off over new background", 32'(c), 32'(model(VEC[8], bg_model)));

    // R2 back-to-back stream
    load(VEC[0]);
    @(negedge clk);
    px = 12'd10; py = 12'd10; pv_i = 1'b1;
    @(negedge clk);
    px = 12'd150;
    @(negedge clk);
    pv_i = 1'b0;
    check("R2 stream first", 32'({pv_o, rgb_o}), {7'd0, 1'b1, 24'h112233});
    @(negedge clk);
    check("R2 stream second", 32'({pv_o, rgb_o}), {7'd0, 1'b1, 24'h204060});
    @(negedge clk);
    check("R2 stream drains", 32'(pv_o), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule